// File: doc/BRIEF.md
# Lexical-Level Frame Address Generator

This block turns an operand reference of a block-structured program into a linear word address. A reference is a 14-bit couple. Its upper field selects a lexical level and its lower field gives a word offset inside the stack frame that is active for that level. The block holds one frame register per level. Each register stores the word address where that level's frame starts, plus a frame length in words. The operand address is the selected frame base plus the offset. Because this is an addition and not a bit concatenation, frames can start at any word, can differ in size and can sit anywhere in the address space. They need not be adjacent.

A call or return sequencer, outside this block, rewrites the frame registers through a single write port whenever the set of visible levels changes. A lookup that names the level being written in the same cycle sees the new contents. Results appear one cycle after the lookup strobe, together with a fault flag. The flag is raised when the offset falls outside the frame or when the addition runs past the top of the address space.

Top module: `frame_base_addr_unit`

## Requirements
- R1: After reset, out_vld and out_fault are 0, and every level holds base 0 and length 0. A lookup made before any write therefore returns the bare offset as the address, with out_fault set.
- R2: The couple in req_couple is split with bits [13:9] as the level number (0 to 31) and bits [8:0] as the word offset (0 to 511).
- R3: out_addr equals the selected level's frame base plus the offset, taken modulo 2^20.
- R4: out_vld is 1 exactly in the cycle after a cycle with req_vld high, so lookups on consecutive cycles give results on consecutive cycles. While out_vld is 0, out_addr keeps its last value and out_fault is 0.
- R5: When the offset is greater than or equal to the level's frame length, out_fault is 1. The address is still produced.
- R6: When base plus offset is 2^20 or more, out_fault is 1 and out_addr carries the wrapped low 20 bits. A sum of exactly 2^20-1 is not a fault.
- R7: When wr_en is high at a clock edge, level wr_lvl takes wr_base and wr_len. All other levels keep their contents.
- R8: When a write and a lookup name the same level in the same cycle, the lookup uses the values being written. A lookup of a different level in that cycle uses that level's stored values.
- R9: All 32 levels are independent, and each is addressable with its own base and length.
- R10: The length field is 10 bits, so a length of 512 makes every offset up to 511 legal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Lookup strobe |
| req_couple | input | 14 | Level in [13:9], offset in [8:0] |
| wr_en | input | 1 | Frame register write strobe |
| wr_lvl | input | 5 | Level being written |
| wr_base | input | 20 | New frame base word address |
| wr_len | input | 10 | New frame length in words |
| out_vld | output | 1 | Result valid, one cycle after req_vld |
| out_addr | output | 20 | Linear operand word address |
| out_fault | output | 1 | Bounds or wrap fault for this result |

## Verification
All 32 levels are loaded with distinct bases and lengths, and a table of couples is then streamed on back-to-back cycles. Each entry's address shows whether the level and offset fields were split correctly and whether the right register was chosen. Entries that sit exactly on a frame length, one below it, and at the 512-word maximum separate a correct less-than bound from an off-by-one. Directed cases then cover three things. The first is a base next to the top of the address space, where a sum of 2^20-1 and a sum of 2^20 show the carry fault and the wrap. The second is a write followed by lookups of the written level and a neighbouring level. The third is same-cycle writes that hit and miss the looked-up level, which shows forwarding only where it belongs.

// File: rtl/frame_addr_pkg.sv
package frame_addr_pkg;

   localparam int DEF_ADDR_W = 20;
   localparam int DEF_LVL_W  = 5;
   localparam int DEF_OFS_W  = 9;

   typedef enum logic [1:0] {
      FLT_NONE  = 2'b00,
      FLT_BOUND = 2'b01,
      FLT_CARRY = 2'b10,
      FLT_BOTH  = 2'b11
   } flt_cause_t;

endpackage

// File: rtl/frame_regfile.sv
module frame_regfile
   import frame_addr_pkg::*;
#(
   parameter int ADDR_W    = DEF_ADDR_W,
   parameter int LVL_W     = DEF_LVL_W,
   parameter int OFS_W     = DEF_OFS_W,
   parameter bit WR_BYPASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [LVL_W-1:0]  wr_lvl,
   input  logic [ADDR_W-1:0] wr_base,
   input  logic [OFS_W:0]    wr_len,
   input  logic [LVL_W-1:0]  rd_lvl,
   output logic [ADDR_W-1:0] rd_base,
   output logic [OFS_W:0]    rd_len
);

   localparam int NUM_LVL = 1 << LVL_W;
   localparam int LEN_W   = OFS_W + 1;

   logic [ADDR_W-1:0] base_q [NUM_LVL];
   logic [LEN_W-1:0]  len_q  [NUM_LVL];

   // one storage entry per lexical level
   for (genvar g = 0; g < NUM_LVL; g++) begin : g_entry
      logic sel;
      assign sel = wr_en && (wr_lvl == LVL_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q[g] <= '0;
            len_q[g]  <= '0;
         end else if (sel) begin
            base_q[g] <= wr_base;
            len_q[g]  <= wr_len;
         end
      end
   end

   // read port: optional forwarding of a same-cycle write
   if (WR_BYPASS) begin : g_fwd
      logic hit;
      assign hit     = wr_en && (wr_lvl == rd_lvl);
      assign rd_base = hit ? wr_base : base_q[rd_lvl];
      assign rd_len  = hit ? wr_len  : len_q[rd_lvl];
   end else begin : g_nofwd
      assign rd_base = base_q[rd_lvl];
      assign rd_len  = len_q[rd_lvl];
   end

   // R7
   wr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (base_q[$past(wr_lvl)] == $past(wr_base))
             && (len_q[$past(wr_lvl)] == $past(wr_len)));

   // R8
   fwd_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (WR_BYPASS && wr_en && (wr_lvl == rd_lvl)) |-> (rd_base == wr_base));

endmodule

// File: rtl/frame_addr_calc.sv
module frame_addr_calc
   import frame_addr_pkg::*;
#(
   parameter int ADDR_W = DEF_ADDR_W,
   parameter int OFS_W  = DEF_OFS_W
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [OFS_W:0]    len,
   input  logic [OFS_W-1:0]  ofs,
   output logic [ADDR_W-1:0] addr,
   output logic              fault
);

   localparam int SUM_W = ADDR_W + 1;

   logic [SUM_W-1:0] sum;
   flt_cause_t       cause;

   assign sum  = {1'b0, base} + SUM_W'(ofs);
   assign addr = sum[ADDR_W-1:0];

   always_comb begin
      cause = flt_cause_t'({sum[ADDR_W], ({1'b0, ofs} >= len)});
   end

   assign fault = (cause != FLT_NONE);

endmodule

// File: rtl/frame_base_addr_unit.sv
module frame_base_addr_unit
   import frame_addr_pkg::*;
#(
   parameter int ADDR_W    = DEF_ADDR_W,
   parameter int LVL_W     = DEF_LVL_W,
   parameter int OFS_W     = DEF_OFS_W,
   parameter bit WR_BYPASS = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_vld,
   input  logic [LVL_W+OFS_W-1:0]   req_couple,
   input  logic                     wr_en,
   input  logic [LVL_W-1:0]         wr_lvl,
   input  logic [ADDR_W-1:0]        wr_base,
   input  logic [OFS_W:0]           wr_len,
   output logic                     out_vld,
   output logic [ADDR_W-1:0]        out_addr,
   output logic                     out_fault
);

   localparam int COUPLE_W = LVL_W + OFS_W;

   initial begin
      assert (ADDR_W > OFS_W) else $error("frame base narrower than offset");
      assert (LVL_W >= 1 && LVL_W <= 8) else $error("level width out of range");
      assert (OFS_W >= 1) else $error("offset width out of range");
   end

   logic [LVL_W-1:0]  req_lvl;
   logic [OFS_W-1:0]  req_ofs;
   logic [ADDR_W-1:0] sel_base;
   logic [OFS_W:0]    sel_len;
   logic [ADDR_W-1:0] calc_addr;
   logic              calc_fault;

   assign req_lvl = req_couple[COUPLE_W-1:OFS_W];
   assign req_ofs = req_couple[OFS_W-1:0];

   frame_regfile #(
      .ADDR_W    (ADDR_W),
      .LVL_W     (LVL_W),
      .OFS_W     (OFS_W),
      .WR_BYPASS (WR_BYPASS)
   ) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_lvl  (wr_lvl),
      .wr_base (wr_base),
      .wr_len  (wr_len),
      .rd_lvl  (req_lvl),
      .rd_base (sel_base),
      .rd_len  (sel_len)
   );

   frame_addr_calc #(
      .ADDR_W (ADDR_W),
      .OFS_W  (OFS_W)
   ) calc_i (
      .base  (sel_base),
      .len   (sel_len),
      .ofs   (req_ofs),
      .addr  (calc_addr),
      .fault (calc_fault)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld   <= 1'b0;
         out_addr  <= '0;
         out_fault <= 1'b0;
      end else begin
         out_vld   <= req_vld;
         out_fault <= req_vld & calc_fault;
         if (req_vld) out_addr <= calc_addr;
      end
   end

   // R4
   vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> out_vld);

   // R4
   vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> (!out_vld && $stable(out_addr)));

   // R1
   fault_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_vld |-> !out_fault);

   // R5
   bound_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && ({1'b0, req_ofs} >= sel_len)) |=> out_fault);

   // R6
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && !calc_fault) |=> (out_addr >= $past(sel_base)));

endmodule

// File: tb/frame_base_addr_unit_tb.sv
module frame_base_addr_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_vld = 1'b0;
   logic [13:0] req_couple = '0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_lvl = '0;
   logic [19:0] wr_base = '0;
   logic [9:0]  wr_len = '0;
   logic        out_vld;
   logic [19:0] out_addr;
   logic        out_fault;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   frame_base_addr_unit dut_i (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_couple(req_couple),
      .wr_en(wr_en), .wr_lvl(wr_lvl), .wr_base(wr_base), .wr_len(wr_len),
      .out_vld(out_vld), .out_addr(out_addr), .out_fault(out_fault)
   );

   // {level, offset, expected address, expected fault}
   localparam logic [34:0] VEC [10] = '{
      {5'd0,  9'd0,   20'h00123, 1'b0},  // R3
      {5'd0,  9'd15,  20'h00132, 1'b0},  // R5 last legal word
      {5'd0,  9'd16,  20'h00133, 1'b1},  // R5 first illegal word
      {5'd1,  9'd31,  20'h08142, 1'b0},
      {5'd1,  9'd32,  20'h08143, 1'b1},
      {5'd5,  9'd95,  20'h28182, 1'b0},
      {5'd31, 9'd511, 20'hF8322, 1'b0},  // R10
      {5'd31, 9'd0,   20'hF8123, 1'b0},  // R9
      {5'd16, 9'd200, 20'h801EB, 1'b0},  // R2
      {5'd20, 9'd400, 20'hA02B3, 1'b1}
   };

   function automatic logic [19:0] base_of(int l);
      return 20'(l * 32'h8000 + 32'h123);
   endfunction

   function automatic logic [9:0] len_of(int l);
      return 10'(16 * l + 16);
   endfunction

   task automatic chk(string req, logic [19:0] a_exp, logic f_exp);
      checks++;
      if (out_vld !== 1'b1 || out_addr !== a_exp || out_fault !== f_exp) begin
         failures++;
         $display("FAIL %s vld/addr/fault actual=%b/%h/%b expected=1/%h/%b",
                  req, out_vld, out_addr, out_fault, a_exp, f_exp);
      end
   endtask

   task automatic do_write(logic [4:0] l, logic [19:0] b, logic [9:0] n);
      @(negedge clk);
      wr_en = 1'b1; wr_lvl = l; wr_base = b; wr_len = n;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic lookup(logic [4:0] l, logic [8:0] o, logic [19:0] a_exp,
                         logic f_exp, string req);
      @(negedge clk);
      req_vld = 1'b1; req_couple = {l, o};
      @(negedge clk);
      req_vld = 1'b0;
      chk(req, a_exp, f_exp);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog R4 actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (out_vld !== 1'b0 || out_fault !== 1'b0) begin
         failures++;
         $display("FAIL R1 reset vld/fault actual=%b/%b expected=0/0", out_vld, out_fault);
      end
      rst_n = 1'b1;

      // R1: unwritten level: base 0, length 0
      lookup(5'd3, 9'd5, 20'h00005, 1'b1, "R1");

      for (int l = 0; l < 32; l++) do_write(5'(l), base_of(l), len_of(l));

      // table streamed on back-to-back cycles (R4)
      for (int i = 0; i <= 10; i++) begin
         @(negedge clk);
         if (i > 0) chk($sformatf("R3 vec%0d", i - 1), VEC[i-1][20:1], VEC[i-1][0]);
         if (i < 10) begin
            req_vld = 1'b1; req_couple = VEC[i][34:21];
         end else begin
            req_vld = 1'b0;
         end
      end
      // R4: idle cycle, address held
      @(negedge clk);
      checks++;
      if (out_vld !== 1'b0 || out_fault !== 1'b0 || out_addr !== 20'hA02B3) begin
         failures++;
         $display("FAIL R4 idle vld/fault/addr actual=%b/%b/%h expected=0/0/a02b3",
                  out_vld, out_fault, out_addr);
      end

      // R6: top of the address space
      do_write(5'd7, 20'hFFF00, 10'd512);
      lookup(5'd7, 9'hFF,  20'hFFFFF, 1'b0, "R6 edge");
      lookup(5'd7, 9'h100, 20'h00000, 1'b1, "R6 wrap");
      lookup(5'd7, 9'h1FF, 20'h000FF, 1'b1, "R6 wrap high");

      // R7: rewrite one level, neighbour untouched
      do_write(5'd9, 20'h33330, 10'd4);
      lookup(5'd9, 9'd3, 20'h33333, 1'b0, "R7 new");
      lookup(5'd9, 9'd4, 20'h33334, 1'b1, "R7 new length");
      lookup(5'd8, 9'd3, 20'h40126, 1'b0, "R7 neighbour");

      // R8: same-cycle write hit
      @(negedge clk);
      wr_en = 1'b1; wr_lvl = 5'd12; wr_base = 20'h40000; wr_len = 10'd8;
      req_vld = 1'b1; req_couple = {5'd12, 9'd3};
      @(negedge clk);
      wr_en = 1'b0; req_vld = 1'b0;
      chk("R8 hit", 20'h40003, 1'b0);
      // R8: same-cycle write to another level
      @(negedge clk);
      wr_en = 1'b1; wr_lvl = 5'd12; wr_base = 20'h40000; wr_len = 10'd2;
      req_vld = 1'b1; req_couple = {5'd13, 9'd3};
      @(negedge clk);
      wr_en = 1'b0; req_vld = 1'b0;
      chk("R8 miss", 20'h68126, 1'b0);
      lookup(5'd12, 9'd3, 20'h40003, 1'b1, "R8 committed");

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule